// File: doc/BRIEF.md
# USB Device Status Indicator Generator

This block turns a handful of internal USB device events into four status pins. It watches a bus-activity strobe and starts a counter on every strobe. When the counter runs out, the block decides the host has put the device into suspend. It also tracks whether the device has been configured. From these two facts it drives three pins: a suspend indicator, a configured indicator and a low-power indicator. A fourth pin is a traffic LED that lights while a serial-peripheral transfer is busy.

The suspend timeout is set by two parameters: the clock rate in kHz and the timeout in microseconds. The default timeout is 3000 µs. While the device is suspended, bus-activity strobes are ignored. Only an explicit resume event or a USB bus reset wakes it, and a device reset (the block's reset) also brings it back awake. Each pin has its own function enable. When an enable is clear, that pin rests at its idle level, but the internal tracking keeps running. Setting the enable again therefore shows the current state at once.

Top module: `usb_status_ind`

## Requirements
- R1: With LIMIT = CLK_KHZ*SUSPEND_US/1000, the device enters suspend on the clock edge that samples the (LIMIT+1)-th consecutive cycle with no `bus_act`, `bus_reset` or `resume_det`. Any of these three inputs restarts the count.
- R2: `susp_n` is low while suspended and high otherwise. It is high after reset.
- R3: While suspended, a sampled `resume_det` or `bus_reset` clears suspend at that edge. Reset also clears suspend.
- R4: While suspended, `bus_act` alone has no effect, and the device stays suspended.
- R5: `cfg_n` is high after reset. It is low when the device is configured and not suspended, and high otherwise.
- R6: `lowpwr` is low after reset. It is high when the device is configured and not suspended, and low otherwise.
- R7: A sampled `cfg_evt` marks the device configured. A sampled `bus_reset` marks it unconfigured and wins over `cfg_evt` in the same cycle. Reset marks it unconfigured.
- R8: `led_n` goes low on the edge after `spi_busy` is sampled high with `func_en[3]` set, and is high otherwise. It is high after reset.
- R9: The `func_en` bits are 0 = suspend pin, 1 = configured pin, 2 = low-power pin, 3 = LED. A clear bit holds its pin at the idle level: `susp_n` high, `cfg_n` high, `lowpwr` low, `led_n` high. State tracking continues, so setting the bit again shows the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, which is also the device reset |
| bus_act | input | 1 | One-cycle strobe for each piece of bus traffic seen |
| cfg_evt | input | 1 | Strobe: the device has been configured by the host |
| bus_reset | input | 1 | Strobe: a USB bus reset was detected |
| resume_det | input | 1 | Strobe: resume signaling was detected or generated |
| spi_busy | input | 1 | High while a serial-peripheral transfer is in progress |
| func_en | input | 4 | Per-pin function enables (bit map in R9) |
| susp_n | output | 1 | Suspend indicator, active low |
| cfg_n | output | 1 | Configured indicator, active low |
| lowpwr | output | 1 | Low-power indicator, high when fully powered and configured |
| led_n | output | 1 | Traffic LED, active low |

## Verification
The suspend timer is tried with three patterns, each of which separates an off-by-one count from a correct one:
- steady strobes spaced well inside the timeout;
- a single strobe followed by exactly LIMIT and then LIMIT+1 idle cycles;
- a resume strobe that arrives mid-count while the device is awake.

While suspended, the bench sends bus-activity strobes and then a resume strobe, which shows whether activity wakes the block by itself. It also sends a bus reset, which shows whether waking also drops the configured state. Configure and bus reset are applied in the same cycle to check which one wins. Each enable is cleared across a suspend entry, which shows whether tracking goes on while the pin is held idle. Every pin is also compared on every clock against a behavioural model.

// File: rtl/usb_stat_pkg.sv
// Package: shared pin indices and idle levels for the USB status indicator.
// Assumes: the index order below matches the func_en bit map.
package usb_stat_pkg;
    typedef enum logic [1:0] {
        PIN_SUSP = 2'd0,
        PIN_CFG  = 2'd1,
        PIN_LPWR = 2'd2,
        PIN_LED  = 2'd3
    } pin_idx_e;

    localparam int NUM_STAT_PINS = 3;   // pins fed from link state
    localparam int NUM_PINS      = 4;   // plus the LED
    // Idle level per status pin, index = pin_idx_e: susp high, cfg high, lowpwr low.
    localparam logic [NUM_STAT_PINS-1:0] STAT_IDLE = 3'b011;

    typedef struct packed {
        logic suspended;
        logic configured;
    } link_state_t;
endpackage

// File: rtl/usb_idle_timer.sv
// Module: bus-inactivity timer and suspend flag.
// Counts sampled idle cycles since the last activity, wake or reset. After
// LIMIT+1 idle samples it sets the suspend flag. While suspended, only a wake
// input clears the flag. Assumes all inputs are synchronous to clk.
module usb_idle_timer #(
    parameter int LIMIT = 144000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic wake,
    output logic suspended
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] idle_cnt;

    // Purpose: advance the idle count, enter suspend on timeout, leave it on wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt  <= '0;
            suspended <= 1'b0;
        end else if (suspended) begin
            if (wake) begin
                suspended <= 1'b0;
                idle_cnt  <= '0;
            end
        end else if (act || wake) begin
            idle_cnt <= '0;
        end else if (idle_cnt == LIMIT_C) begin
            suspended <= 1'b1;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R1/R10: traffic or a wake strobe while awake keeps the block awake next cycle.
    p_act_keeps_awake_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && (act || wake)) |=> !suspended);
    // R3: a wake strobe while suspended always ends suspend.
    p_wake_exits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && wake) |=> !suspended);
    // R4: without a wake strobe, suspend is held regardless of activity.
    p_act_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !wake) |=> suspended);
    // R1: the counter never passes its limit.
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LIMIT_C);
endmodule

// File: rtl/usb_cfg_track.sv
// Module: configured-state tracker.
// A configure strobe sets the flag and a bus reset clears it. The bus reset
// has priority. Assumes strobes are one-cycle and synchronous to clk.
module usb_cfg_track (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_evt,
    input  logic bus_reset,
    output logic configured
);
    // Purpose: hold the configured flag across configure and bus-reset events.
    always_ff @(posedge clk) begin
        if (!rst_n)         configured <= 1'b0;
        else if (bus_reset) configured <= 1'b0;
        else if (cfg_evt)   configured <= 1'b1;
    end

    // R7: a bus reset leaves the device unconfigured on the next cycle.
    p_busrst_unconfig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !configured);
    // R7: a configure strobe without a bus reset leaves it configured.
    p_cfg_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_evt && !bus_reset) |=> configured);
endmodule

// File: rtl/usb_pin_mux.sv
// Module: status pin polarity and enable muxing.
// Builds the active level of each state-driven pin from the link state, then
// picks either that level or the pin's idle level from its enable bit.
// Purely combinational. Assumes enables are quasi-static.
module usb_pin_mux
    import usb_stat_pkg::*;
#(
    parameter int NP = NUM_STAT_PINS
) (
    input  link_state_t   st,
    input  logic [NP-1:0] en,
    output logic [NP-1:0] pin
);
    logic          awake_cfg;
    logic [NP-1:0] lvl;

    // Purpose: map link state onto per-pin active levels.
    always_comb begin
        awake_cfg     = st.configured && !st.suspended;
        lvl           = '0;
        lvl[PIN_SUSP] = !st.suspended;
        lvl[PIN_CFG]  = !awake_cfg;
        lvl[PIN_LPWR] = awake_cfg;
    end

    for (genvar i = 0; i < NP; i++) begin : g_pin
        assign pin[i] = en[i] ? lvl[i] : STAT_IDLE[i];
    end
endmodule

// File: rtl/usb_led_drv.sv
// Module: traffic LED driver.
// Registers the busy input so the LED output is glitch-free, active low.
// Assumes spi_busy is synchronous to clk.
module usb_led_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic en,
    output logic led_n
);
    // Purpose: light the LED one cycle after an enabled busy sample.
    always_ff @(posedge clk) begin
        if (!rst_n) led_n <= 1'b1;
        else        led_n <= !(busy && en);
    end
endmodule

// File: rtl/usb_status_ind.sv
// Module: USB device status indicator generator (top).
// Combines the inactivity timer, the configured tracker, the pin polarity mux
// and the LED driver. The suspend timeout is LIMIT = CLK_KHZ*SUSPEND_US/1000
// cycles. Assumes every input is synchronous to clk, and rst_n is the device reset.
module usb_status_ind
    import usb_stat_pkg::*;
#(
    parameter int CLK_KHZ    = 48000,
    parameter int SUSPEND_US = 3000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_act,
    input  logic                cfg_evt,
    input  logic                bus_reset,
    input  logic                resume_det,
    input  logic                spi_busy,
    input  logic [NUM_PINS-1:0] func_en,
    output logic                susp_n,
    output logic                cfg_n,
    output logic                lowpwr,
    output logic                led_n
);
    localparam int LIMIT = (CLK_KHZ * SUSPEND_US) / 1000;

    link_state_t              st;
    logic                     wake;
    logic [NUM_STAT_PINS-1:0] stat_pins;

    assign wake = resume_det || bus_reset;

    usb_idle_timer #(.LIMIT(LIMIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (bus_act),
        .wake      (wake),
        .suspended (st.suspended)
    );

    usb_cfg_track u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_evt    (cfg_evt),
        .bus_reset  (bus_reset),
        .configured (st.configured)
    );

    usb_pin_mux #(.NP(NUM_STAT_PINS)) u_mux (
        .st  (st),
        .en  (func_en[NUM_STAT_PINS-1:0]),
        .pin (stat_pins)
    );

    usb_led_drv u_led (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (spi_busy),
        .en    (func_en[PIN_LED]),
        .led_n (led_n)
    );

    assign susp_n = stat_pins[PIN_SUSP];
    assign cfg_n  = stat_pins[PIN_CFG];
    assign lowpwr = stat_pins[PIN_LPWR];

    // R5/R6: with both enabled, the configured and low-power pins stay opposite.
    p_cfg_lp_opposed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (func_en[PIN_CFG] && func_en[PIN_LPWR]) |-> (cfg_n != lowpwr));
    // R2/R6: a low suspend pin never coexists with a high low-power pin.
    p_susp_forces_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (func_en[PIN_SUSP] && !susp_n) |-> !lowpwr);
    // R8: an enabled busy sample lights the LED on the next cycle.
    p_led_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (func_en[PIN_LED] && spi_busy) |=> !led_n);
    // R9: a disabled LED function leaves the LED dark on the next cycle.
    p_led_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !func_en[PIN_LED] |=> led_n);
endmodule

// File: tb/sim_usb_status_ind.sv
module sim_usb_status_ind;
    localparam int CLK_KHZ    = 10;
    localparam int SUSPEND_US = 3000;
    localparam int LIMIT      = (CLK_KHZ * SUSPEND_US) / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_act = 1'b0, cfg_evt = 1'b0, bus_reset = 1'b0, resume_det = 1'b0;
    logic       spi_busy = 1'b0;
    logic [3:0] func_en = 4'hF;
    logic       susp_n, cfg_n, lowpwr, led_n;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    bit m_susp = 0, m_cfg = 0, m_led = 1;
    int m_idle = 0;

    always #4 clk = ~clk;

    usb_status_ind #(.CLK_KHZ(CLK_KHZ), .SUSPEND_US(SUSPEND_US)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_act), .cfg_evt(cfg_evt),
        .bus_reset(bus_reset), .resume_det(resume_det), .spi_busy(spi_busy),
        .func_en(func_en), .susp_n(susp_n), .cfg_n(cfg_n), .lowpwr(lowpwr),
        .led_n(led_n)
    );

    // behavioural model updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_susp = 0; m_idle = 0; m_cfg = 0; m_led = 1;
        end else begin
            if (m_susp) begin
                if (resume_det || bus_reset) begin m_susp = 0; m_idle = 0; end
            end else if (bus_act || resume_det || bus_reset) begin
                m_idle = 0;
            end else if (m_idle >= LIMIT) begin
                m_susp = 1;
            end else begin
                m_idle++;
            end
            if (bus_reset) m_cfg = 0;
            else if (cfg_evt) m_cfg = 1;
            m_led = !(spi_busy && func_en[3]);
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // every-cycle comparison against the model, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(susp_n, func_en[0] ? !m_susp : 1'b1, "R2 susp_n model");
            chk(cfg_n,  func_en[1] ? !(m_cfg && !m_susp) : 1'b1, "R5 cfg_n model");
            chk(lowpwr, func_en[2] ? (m_cfg && !m_susp) : 1'b0, "R6 lowpwr model");
            chk(led_n,  m_led, "R8 led_n model");
        end
    end

    // stimulus point: 3 ns after each rising edge
    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #3; end
    endtask

    task automatic pulse_act();
        bus_act = 1; tick(); bus_act = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        // reset state
        chk(susp_n, 1'b1, "R2 reset");
        chk(cfg_n, 1'b1, "R5 reset");
        chk(lowpwr, 1'b0, "R6 reset");
        chk(led_n, 1'b1, "R8 reset");

        // configure
        cfg_evt = 1; tick(); cfg_evt = 0;
        chk(cfg_n, 1'b0, "R7 configured cfg_n");
        chk(lowpwr, 1'b1, "R7 configured lowpwr");

        // regular traffic keeps it awake
        for (int i = 0; i < 10; i++) begin pulse_act(); tick(9); end
        chk(susp_n, 1'b1, "R1 steady traffic");

        // timeout boundary
        pulse_act();
        tick(LIMIT);
        chk(susp_n, 1'b1, "R1 LIMIT idle cycles");
        tick();
        chk(susp_n, 1'b0, "R1 LIMIT+1 idle cycles");
        chk(cfg_n, 1'b1, "R5 suspended");
        chk(lowpwr, 1'b0, "R6 suspended");

        // activity ignored while suspended
        for (int i = 0; i < 4; i++) begin pulse_act(); tick(); end
        chk(susp_n, 1'b0, "R4 activity in suspend");

        // resume wakes
        resume_det = 1; tick(); resume_det = 0;
        chk(susp_n, 1'b1, "R3 resume");
        chk(cfg_n, 1'b0, "R5 resumed");
        chk(lowpwr, 1'b1, "R6 resumed");

        // wake strobe while awake restarts count (R1)
        tick(LIMIT - 5);
        resume_det = 1; tick(); resume_det = 0;
        tick(LIMIT);
        chk(susp_n, 1'b1, "R1 resume restarts count");
        tick();
        chk(susp_n, 1'b0, "R1 suspend after restart");

        // bus reset wakes and unconfigures
        bus_reset = 1; tick(); bus_reset = 0;
        chk(susp_n, 1'b1, "R3 bus reset wake");
        chk(cfg_n, 1'b1, "R7 bus reset unconfig");
        chk(lowpwr, 1'b0, "R7 bus reset lowpwr");

        // same-cycle configure and bus reset
        cfg_evt = 1; bus_reset = 1; tick(); cfg_evt = 0; bus_reset = 0;
        chk(cfg_n, 1'b1, "R7 bus reset priority");
        cfg_evt = 1; tick(); cfg_evt = 0;
        chk(cfg_n, 1'b0, "R7 reconfigure");

        // enables off across a suspend entry
        func_en = 4'h0;
        spi_busy = 1;
        tick(LIMIT + 3);
        chk(susp_n, 1'b1, "R9 susp idle");
        chk(cfg_n, 1'b1, "R9 cfg idle");
        chk(lowpwr, 1'b0, "R9 lowpwr idle");
        chk(led_n, 1'b1, "R9 led idle");
        func_en = 4'hF;
        #1;
        chk(susp_n, 1'b0, "R9 tracking continued susp");
        chk(lowpwr, 1'b0, "R9 tracking continued lowpwr");
        tick();
        chk(led_n, 1'b0, "R8 led on");
        spi_busy = 0; tick();
        chk(led_n, 1'b1, "R8 led off");

        // device reset while suspended
        rst_n = 0; tick(); rst_n = 1; tick();
        chk(susp_n, 1'b1, "R3 device reset wake");
        chk(cfg_n, 1'b1, "R7 device reset unconfig");

        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule